// File: doc/BRIEF.md
# Sum-Product Check Node Processor (Degree 6)

This block performs the check-side half of one sum-product iteration for a regular low-density parity-check decoder in which every parity check joins six bits. It takes six variable-to-check messages in a single cycle. Each message is a sign-magnitude number with three fraction bits. For each of the six edges it returns the extrinsic check-to-variable message, which is the message built from the other five edges only.

The magnitude path works in the transformed domain given by f(x) = -ln(tanh(x/2)). Each incoming magnitude goes through f, and the six results are added once. Each edge's own term is then taken away from that total. The remainder is clamped to the largest magnitude code and sent through f a second time. f is evaluated with a small compressed table: the 5-bit magnitude is first folded into a 4-bit index whose steps are fine near zero and coarse towards the top of the range. The sign path XORs all six signs once and then cancels each edge's own sign. The results are registered and qualified by a valid strobe that follows the input strobe by one clock.

Top module: `ldpc_cnu`

## Requirements
- R1: A message is 6 bits: bit 5 is the sign (1 = negative) and bits 4:0 are an unsigned magnitude in units of 0.125 (0.0 to 3.875). Edge k occupies bits 6k+5:6k of the packed in_msg and out_msg buses.
- R2: The transform maps magnitude codes 0..7 to 28, 19, 15, 12, 10, 9, 8, 7 (in units of 0.125). Codes 8-9 map to 5, 10-11 to 4, 12-13 to 3, 14-19 to 2, 20-27 to 1, and 28-31 to 0.
- R3: The output magnitude of edge k is the transform of the clamped sum of the transformed magnitudes of the five other edges.
- R4: Before the second transform, the five-term sum is clamped to 31, so any sum of 31 or more yields magnitude 0. With all six input magnitudes zero, every output magnitude is 0.
- R5: The output sign of edge k is the XOR of the signs of the five other edges. The XOR of all six output signs therefore equals the XOR of all six input signs.
- R6: out_valid is high in exactly the cycle after a cycle with in_valid high. The out_msg value then present belongs to that input.
- R7: While in_valid is low, out_msg keeps its previous value whatever in_msg carries.
- R8: Synchronous active-high rst clears out_valid and out_msg to zero on the next clock edge.
- R9: No output magnitude ever exceeds 28 (3.5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_msg in this cycle |
| in_msg | input | 36 | Six packed variable-to-check messages |
| out_valid | output | 1 | Qualifies out_msg, one cycle after in_valid |
| out_msg | output | 36 | Six packed extrinsic check-to-variable messages |

## Verification
The path holds no state except the output register, so every fault shows up on out_msg in the cycle after the vector that exposes it. A wrong entry in the compressed table, or a misplaced fold boundary, corrupts only the vectors whose magnitudes land on that code. For this reason the bench sweeps every magnitude code on one edge and adds directed vectors that put the five-term sum exactly at and just past the clamp point. A faulty exclusion or sign cancellation alters all six edges at once, and a faulty output register shows up either as a changed value while in_valid is low or as a misplaced out_valid.

// File: rtl/ldpc_cnu_pkg.sv
package ldpc_cnu_pkg;
  // Default geometry of the check node processor
  localparam int CNU_DEG   = 6;
  localparam int CNU_MAG_W = 5;
  localparam int CNU_ACC_W = 8;
  localparam int CNU_IDX_W = 4;

  // Fold a 5-bit magnitude code into the compressed 4-bit table index:
  // unit steps below 1.0, pairs between 1.0 and 1.75, wider groups above.
  function automatic logic [CNU_IDX_W-1:0] psi_fold(input logic [CNU_MAG_W-1:0] m);
    logic [CNU_IDX_W-1:0] r;
    if (m < 5'd8)       r = m[3:0];
    else if (m < 5'd10) r = 4'd8;
    else if (m < 5'd12) r = 4'd9;
    else if (m < 5'd14) r = 4'd10;
    else if (m < 5'd20) r = 4'd11;
    else if (m < 5'd28) r = 4'd12;
    else                r = 4'd13;
    return r;
  endfunction
endpackage

// File: rtl/cnu_psi_lut.sv
module cnu_psi_lut
  import ldpc_cnu_pkg::*;
#(
  parameter int MAG_W = CNU_MAG_W
) (
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] psi_o
);
  logic [CNU_IDX_W-1:0] idx;

  always_comb begin
    idx = psi_fold(mag_i);
    unique case (idx)
      4'd0:    psi_o = MAG_W'(28);
      4'd1:    psi_o = MAG_W'(19);
      4'd2:    psi_o = MAG_W'(15);
      4'd3:    psi_o = MAG_W'(12);
      4'd4:    psi_o = MAG_W'(10);
      4'd5:    psi_o = MAG_W'(9);
      4'd6:    psi_o = MAG_W'(8);
      4'd7:    psi_o = MAG_W'(7);
      4'd8:    psi_o = MAG_W'(5);
      4'd9:    psi_o = MAG_W'(4);
      4'd10:   psi_o = MAG_W'(3);
      4'd11:   psi_o = MAG_W'(2);
      4'd12:   psi_o = MAG_W'(1);
      default: psi_o = MAG_W'(0);
    endcase
  end
endmodule

// File: rtl/cnu_extrinsic_sum.sv
module cnu_extrinsic_sum #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5,
  parameter int ACC_W = 8
) (
  input  logic [DEG*MAG_W-1:0] psi_i,
  output logic [DEG*MAG_W-1:0] sum_o
);
  localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'((1 << MAG_W) - 1);

  logic [ACC_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < DEG; i++)
      total = total + ACC_W'(psi_i[i*MAG_W +: MAG_W]);
  end

  for (genvar k = 0; k < DEG; k++) begin : g_edge
    logic [ACC_W-1:0] partial;
    always_comb begin
      partial = total - ACC_W'(psi_i[k*MAG_W +: MAG_W]);
      if (partial > SAT_MAX) sum_o[k*MAG_W +: MAG_W] = SAT_MAX[MAG_W-1:0];
      else                   sum_o[k*MAG_W +: MAG_W] = partial[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/cnu_sign_net.sv
module cnu_sign_net #(
  parameter int DEG = 6
) (
  input  logic [DEG-1:0] sign_i,
  output logic [DEG-1:0] sign_o
);
  logic parity;

  always_comb begin
    parity = ^sign_i;
    sign_o = sign_i ^ {DEG{parity}};
  end
endmodule

// File: rtl/ldpc_cnu.sv
module ldpc_cnu
  import ldpc_cnu_pkg::*;
#(
  parameter int DEG   = CNU_DEG,
  parameter int MAG_W = CNU_MAG_W,
  parameter int ACC_W = CNU_ACC_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [DEG*(MAG_W+1)-1:0]   in_msg,
  output logic                       out_valid,
  output logic [DEG*(MAG_W+1)-1:0]   out_msg
);
  localparam int MSG_W = MAG_W + 1;

  logic [DEG-1:0]       in_sign;
  logic [DEG-1:0]       ext_sign;
  logic [DEG*MAG_W-1:0] psi_fwd;
  logic [DEG*MAG_W-1:0] ext_sum;
  logic [DEG*MAG_W-1:0] psi_back;
  logic [DEG*MSG_W-1:0] next_msg;

  for (genvar k = 0; k < DEG; k++) begin : g_lane
    assign in_sign[k] = in_msg[k*MSG_W + MAG_W];

    cnu_psi_lut #(.MAG_W(MAG_W)) u_fwd (
      .mag_i (in_msg[k*MSG_W +: MAG_W]),
      .psi_o (psi_fwd[k*MAG_W +: MAG_W])
    );

    cnu_psi_lut #(.MAG_W(MAG_W)) u_back (
      .mag_i (ext_sum[k*MAG_W +: MAG_W]),
      .psi_o (psi_back[k*MAG_W +: MAG_W])
    );

    assign next_msg[k*MSG_W +: MSG_W] = {ext_sign[k], psi_back[k*MAG_W +: MAG_W]};
  end

  cnu_extrinsic_sum #(.DEG(DEG), .MAG_W(MAG_W), .ACC_W(ACC_W)) u_sum (
    .psi_i (psi_fwd),
    .sum_o (ext_sum)
  );

  cnu_sign_net #(.DEG(DEG)) u_sign (
    .sign_i (in_sign),
    .sign_o (ext_sign)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_msg <= next_msg;
    end
  end
endmodule

// File: rtl/ldpc_cnu_checker.sv
module ldpc_cnu_checker #(
  parameter int DEG   = 6,
  parameter int MAG_W = 5,
  parameter int ACC_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [DEG*(MAG_W+1)-1:0] in_msg,
  input logic                     out_valid,
  input logic [DEG*(MAG_W+1)-1:0] out_msg
);
  localparam int MSG_W = MAG_W + 1;

  logic in_parity, out_parity, in_all_zero, out_all_zero;

  always_comb begin
    in_parity    = 1'b0;
    out_parity   = 1'b0;
    in_all_zero  = 1'b1;
    out_all_zero = 1'b1;
    for (int i = 0; i < DEG; i++) begin
      in_parity  = in_parity  ^ in_msg[i*MSG_W + MAG_W];
      out_parity = out_parity ^ out_msg[i*MSG_W + MAG_W];
      if (in_msg[i*MSG_W +: MAG_W]  != '0) in_all_zero  = 1'b0;
      if (out_msg[i*MSG_W +: MAG_W] != '0) out_all_zero = 1'b0;
    end
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_msg == '0));

  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_msg));

  assert_sign_parity_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_parity == $past(in_parity)));

  assert_zero_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_all_zero) |=> out_all_zero);

  for (genvar k = 0; k < DEG; k++) begin : g_bound
    assert_mag_bound_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_msg[k*MSG_W +: MAG_W] <= MAG_W'(28)));
  end
endmodule

bind ldpc_cnu ldpc_cnu_checker #(.DEG(DEG), .MAG_W(MAG_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_msg    (in_msg),
  .out_valid (out_valid),
  .out_msg   (out_msg)
);

// File: tb/ldpc_cnu_tb.sv
`timescale 1ns/1ps
module ldpc_cnu_tb;
  localparam int DEG = 6;
  localparam int MW  = 6;
  localparam int BW  = DEG*MW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_msg = '0;
  logic          out_valid;
  logic [BW-1:0] out_msg;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  ldpc_cnu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(out_valid), .out_msg(out_msg)
  );

  // R2 transform, written from the requirement
  function automatic int psi_ref(input int m);
    if (m == 0) return 28;
    if (m == 1) return 19;
    if (m == 2) return 15;
    if (m == 3) return 12;
    if (m == 4) return 10;
    if (m == 5) return 9;
    if (m == 6) return 8;
    if (m == 7) return 7;
    if (m < 10) return 5;
    if (m < 12) return 4;
    if (m < 14) return 3;
    if (m < 20) return 2;
    if (m < 28) return 1;
    return 0;
  endfunction

  // R3/R4/R5 expected output, edge by edge over the other five
  function automatic logic [BW-1:0] model(input logic [BW-1:0] m);
    logic [BW-1:0] r;
    r = '0;
    for (int k = 0; k < DEG; k++) begin
      int s;
      logic sg;
      s = 0;
      sg = 1'b0;
      for (int j = 0; j < DEG; j++) begin
        if (j != k) begin
          s  = s + psi_ref(int'(m[j*MW +: 5]));
          sg = sg ^ m[j*MW + 5];
        end
      end
      if (s > 31) s = 31;
      r[k*MW +: MW] = {sg, 5'(psi_ref(s))};
    end
    return r;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_msgs(input string tag, input logic [BW-1:0] exp);
    for (int k = 0; k < DEG; k++) begin
      n_checks++;
      if (out_msg[k*MW +: MW] !== exp[k*MW +: MW]) begin
        n_errors++;
        $display("FAIL %s edge %0d: actual %b expected %b", tag, k,
                 out_msg[k*MW +: MW], exp[k*MW +: MW]);
      end
    end
  endtask

  function automatic logic [BW-1:0] pack(input int m0, m1, m2, m3, m4, m5);
    logic [BW-1:0] r;
    r[0*MW +: MW] = MW'(m0); r[1*MW +: MW] = MW'(m1); r[2*MW +: MW] = MW'(m2);
    r[3*MW +: MW] = MW'(m3); r[4*MW +: MW] = MW'(m4); r[5*MW +: MW] = MW'(m5);
    return r;
  endfunction

  // drive one vector with in_valid high, check it one clock later (R6)
  task automatic apply(input string tag, input logic [BW-1:0] v);
    @(negedge clk);
    in_valid = 1'b1;
    in_msg   = v;
    @(negedge clk);
    check_bit("R6 out_valid", out_valid, 1'b1);
    check_msgs(tag, model(v));
  endtask

  initial begin
    logic [BW-1:0] last;
    void'($urandom(32'h5eed_0c11));
    repeat (3) @(negedge clk);
    check_bit("R8 reset out_valid", out_valid, 1'b0);
    check_msgs("R8 reset out_msg", '0);
    rst = 1'b0;

    apply("R4 all zero", '0);
    apply("R9 all max", pack(31, 31, 31, 31, 31, 31));
    apply("R5 mixed signs", pack(32+3, 5, 32+12, 32+0, 20, 32+31));
    apply("R3 one weak edge", pack(0, 31, 31, 31, 31, 31));
    apply("R4 sum exactly 32", pack(6, 6, 6, 6, 28, 28));
    apply("R4 sum exactly 31", pack(6, 6, 6, 7, 28, 28));
    apply("R5 all negative", pack(32+9, 32+9, 32+9, 32+9, 32+9, 32+9));
    for (int c = 0; c < 32; c++)
      apply("R2 code sweep", pack(c, 31, 31, 31, 31, 31) | (BW'(c & 1) << 5));

    // R7: hold while idle
    last = model(pack(32+2, 14, 8, 32+27, 1, 19));
    apply("R1 packed fields", pack(32+2, 14, 8, 32+27, 1, 19));
    @(negedge clk);
    in_valid = 1'b0;
    in_msg   = pack(0, 0, 32, 0, 0, 32);
    @(negedge clk);
    check_bit("R6 idle out_valid", out_valid, 1'b0);
    check_msgs("R7 hold", last);
    in_msg = pack(31, 0, 31, 0, 31, 0);
    @(negedge clk);
    check_msgs("R7 hold second", last);

    for (int t = 0; t < 300; t++) begin
      logic [BW-1:0] v;
      for (int k = 0; k < DEG; k++) v[k*MW +: MW] = MW'($urandom_range(0, 63));
      apply("R3 random", v);
    end

    // R8: reset mid-stream
    @(negedge clk);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check_bit("R8 reset out_valid", out_valid, 1'b0);
    check_msgs("R8 reset out_msg", '0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule